// File: doc/BRIEF.md
# Segmented VCO Output Divider

This block divides a VCO clock by a programmable ratio before it reaches an output buffer. The ratio comes from a chain of up to three stages. The front stage divides by two or by three. Each of the two tail stages divides by 2, 4, 6 or 8, and its ratio is chosen with a one-hot code. A path selector sets how many stages feed the output. The total ratio is the product of the ratios of the stages in the path.

Each stage has its own enable, and a master enable gates the whole chain. Any enabled, valid setting of the chain starts from a fixed phase. When the setting is invalid or switched off, the divided output is held low. A small mux at the output picks the divided clock, the undivided VCO clock, or a constant low for the reserved codes.

All registers run on the VCO clock. The division by three uses one extra flop on the falling edge, so the output stays at 50% duty. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `vco_chdiv`

## Requirements
- R1: With `path_sel`=1, the output divides by 2 when `front_odd`=0, and is high for the first clock of each 2-clock period. With `front_odd`=1 it divides by 3, and is high for the first 1.5 clocks of each 3-clock period.
- R2: A tail stage's code selects its ratio as follows: 4'b0001 divides by 2, 4'b0010 by 4, 4'b0100 by 6, 4'b1000 by 8. The total period is the product of the ratios of the stages in the path. The output is high for the first half of the period.
- R3: `path_sel` selects the stages in the path: 3'b001 selects the front stage only, 3'b010 the front stage and the middle stage, 3'b100 all three stages. Any other value holds the divided output low.
- R4: If a tail stage in the path has a code other than the four listed in R2 (including 0), the divided output is held low.
- R5: Clearing `front_en`, or the enable of a tail stage in the path, holds the output low. The enable and code of a tail stage outside the path have no effect, and changing them does not disturb the running phase.
- R6: While `div_en`=0 the divided output is low. When it returns to 1, the divider restarts from phase zero.
- R7: The first rising clock edge that samples a new valid setting starts phase zero. The output is high from that edge, and every stage counter starts from zero.
- R8: `out_sel`=0 gives the divided clock, `out_sel`=1 passes `clk_vco` straight through, and `out_sel`=2 or 3 gives a constant low.
- R9: During reset, and until a valid enabled setting is sampled, the divided output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock, the clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_en | input | 1 | Master enable of the divider chain |
| front_en | input | 1 | Front stage enable |
| front_odd | input | 1 | Front stage ratio: 1 divides by 3, 0 divides by 2 |
| mid_en | input | 1 | Middle stage enable |
| mid_code | input | 4 | Middle stage one-hot ratio code |
| back_en | input | 1 | Last stage enable |
| back_code | input | 4 | Last stage one-hot ratio code |
| path_sel | input | 3 | One-hot number of stages in the path |
| out_sel | input | 2 | Output mux select |
| clk_out | output | 1 | Selected output clock |

## Verification
Two things can coincide in one cycle: a settings change arrives while a stage boundary is due, and a carry is about to ripple into the next stage. The restart must then win over the carry. The bench provokes this by changing ratio codes and the front ratio in the middle of a period, and by toggling fields outside the path while the divider is running. A behavioural period-and-phase model is checked on both clock halves to confirm that the output restarts high at the sampling edge, or keeps its phase when nothing in the path changed.

// File: rtl/vco_chdiv_pkg.sv
package vco_chdiv_pkg;
  localparam int CODE_W = 4;
  localparam int N_TAIL = 2;
  localparam int PATH_W = N_TAIL + 1;
  localparam int DIV_W  = 4;
  localparam int OSEL_W = 2;

  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    logic [PATH_W-1:0]      path;
    logic                   odd;
    div_t [N_TAIL-1:0]      tail_div;
  } cfg_t;

  function automatic div_t code_to_div(input logic [CODE_W-1:0] code);
    div_t d;
    case (code)
      4'b0001: d = 4'd2;
      4'b0010: d = 4'd4;
      4'b0100: d = 4'd6;
      4'b1000: d = 4'd8;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/vco_chdiv_cfg.sv
module vco_chdiv_cfg
  import vco_chdiv_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           master_en,
  input  logic                           front_en,
  input  logic                           front_odd,
  input  logic [N_TAIL-1:0]              tail_en,
  input  logic [N_TAIL-1:0][CODE_W-1:0]  tail_code,
  input  logic [PATH_W-1:0]              path_sel,
  output cfg_t                           cfg_q,
  output logic                           run_q,
  output logic                           load
);
  cfg_t cfg_d;
  logic ok_d;

  always_comb begin
    cfg_d      = '0;
    cfg_d.path = path_sel;
    cfg_d.odd  = front_odd;
    ok_d       = master_en & front_en & $onehot(path_sel);
    for (int i = 0; i < N_TAIL; i++) begin
      if (|(path_sel >> (i + 1))) begin
        cfg_d.tail_div[i] = code_to_div(tail_code[i]);
        ok_d = ok_d & tail_en[i] & (cfg_d.tail_div[i] != '0);
      end
    end
    load = ~ok_d | (cfg_d != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      run_q <= ok_d;
    end
  end

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !run_q); // R6
endmodule

// File: rtl/vco_chdiv_front.sv
module vco_chdiv_front (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic odd,
  input  logic run,
  output logic wave,
  output logic wrap
);
  logic [1:0] cnt_q, cnt_d, last;
  logic       lead_q, lead_d, trail_q, cnt_en;

  always_comb begin
    last   = odd ? 2'd2 : 2'd1;
    cnt_en = load | adv;
    cnt_d  = cnt_q;
    if (load)
      cnt_d = '0;
    else if (adv)
      cnt_d = (cnt_q == last) ? 2'd0 : cnt_q + 2'd1;
    lead_d = (cnt_d == 2'd0);
    wrap   = adv & ~load & (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lead_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      lead_q <= lead_d;
    end
  end

  // half-cycle copy of the lead pulse, stretches the odd ratio to 50% duty
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      trail_q <= 1'b0;
    else
      trail_q <= run & lead_q;
  end

  assign wave = lead_q | (odd & trail_q);

  AST_FRONT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !odd |-> (cnt_q != 2'd2)); // R1
  AST_FRONT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0 && lead_q)); // R7
endmodule

// File: rtl/vco_chdiv_tail.sv
module vco_chdiv_tail #(
  parameter int DIV_W = 4,
  localparam int CNT_W = DIV_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             lvl,
  output logic             carry
);
  logic [CNT_W-1:0] c_q, c_d;
  logic [DIV_W-1:0] last, half;
  logic             lvl_q, lvl_d, c_en, live;

  always_comb begin
    last  = div - 1'b1;
    half  = div >> 1;
    live  = (div != '0);
    c_en  = load | (step & live);
    c_d   = c_q;
    lvl_d = lvl_q;
    if (load) begin
      c_d   = '0;
      lvl_d = 1'b1;
    end else if (step && live) begin
      c_d   = ({1'b0, c_q} == last) ? '0 : c_q + 1'b1;
      lvl_d = ({1'b0, c_d} < half);
    end
    carry = step & ~load & live & ({1'b0, c_q} == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      lvl_q <= 1'b1;
    end else if (c_en) begin
      c_q   <= c_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  AST_TAIL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (c_q == '0 && lvl_q)); // R7
  AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(c_q)); // R2
endmodule

// File: rtl/vco_chdiv.sv
module vco_chdiv
  import vco_chdiv_pkg::*;
(
  input  logic              clk_vco,
  input  logic              rst_n,
  input  logic              div_en,
  input  logic              front_en,
  input  logic              front_odd,
  input  logic              mid_en,
  input  logic [CODE_W-1:0] mid_code,
  input  logic              back_en,
  input  logic [CODE_W-1:0] back_code,
  input  logic [PATH_W-1:0] path_sel,
  input  logic [OSEL_W-1:0] out_sel,
  output logic              clk_out
);
  logic [1:0]                    rst_pipe;
  logic                          rst_s;
  logic [N_TAIL-1:0]             tail_en;
  logic [N_TAIL-1:0][CODE_W-1:0] tail_code;
  cfg_t                          cfg_q;
  logic                          run_q, load;
  logic [N_TAIL:0]               step;
  logic [PATH_W-1:0]             lvl_all;
  logic                          div_lvl;

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign tail_en      = {back_en, mid_en};
  assign tail_code[0] = mid_code;
  assign tail_code[1] = back_code;

  vco_chdiv_cfg u_cfg (
    .clk       (clk_vco),
    .rst_n     (rst_s),
    .master_en (div_en),
    .front_en  (front_en),
    .front_odd (front_odd),
    .tail_en   (tail_en),
    .tail_code (tail_code),
    .path_sel  (path_sel),
    .cfg_q     (cfg_q),
    .run_q     (run_q),
    .load      (load)
  );

  vco_chdiv_front u_front (
    .clk   (clk_vco),
    .rst_n (rst_s),
    .load  (load),
    .adv   (run_q),
    .odd   (cfg_q.odd),
    .run   (run_q),
    .wave  (lvl_all[0]),
    .wrap  (step[0])
  );

  for (genvar g = 0; g < N_TAIL; g++) begin : g_tail
    vco_chdiv_tail #(.DIV_W(DIV_W)) u_tail (
      .clk   (clk_vco),
      .rst_n (rst_s),
      .load  (load),
      .step  (step[g]),
      .div   (cfg_q.tail_div[g]),
      .lvl   (lvl_all[g+1]),
      .carry (step[g+1])
    );
  end

  assign div_lvl = run_q & |(cfg_q.path & lvl_all);

  always_comb begin
    case (out_sel)
      2'd0:    clk_out = div_lvl;
      2'd1:    clk_out = clk_vco;
      default: clk_out = 1'b0;
    endcase
  end

  AST_IDLE_LOW: assert property (@(posedge clk_vco) disable iff (!rst_s)
    (out_sel == 2'd0 && !run_q) |-> !clk_out); // R4
  AST_RESERVED_LOW: assert property (@(posedge clk_vco) disable iff (!rst_s)
    out_sel[1] |-> !clk_out); // R8
endmodule

// File: tb/vco_chdiv_test.sv
module vco_chdiv_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, div_en, front_en, front_odd, mid_en, back_en, clk_out;
  logic [3:0] mid_code, back_code;
  logic [2:0] path_sel;
  logic [1:0] out_sel;

  int    n_vec = 0, n_bad = 0;
  string req = "R9";
  int    k = 0, pkey = 0, per = 2;
  bit    run_m = 0, done = 0;

  vco_chdiv uut (
    .clk_vco(clk), .rst_n(rst_n), .div_en(div_en), .front_en(front_en),
    .front_odd(front_odd), .mid_en(mid_en), .mid_code(mid_code),
    .back_en(back_en), .back_code(back_code), .path_sel(path_sel),
    .out_sel(out_sel), .clk_out(clk_out));

  function automatic int div_of(logic [3:0] c);
    case (c)
      4'd1: return 2;
      4'd2: return 4;
      4'd4: return 6;
      4'd8: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int depth, d2, d3, key;
    bit ok;
    if (!rst_n) begin k = 0; run_m = 0; pkey = 0; return; end
    depth = (path_sel == 3'd1) ? 0 : (path_sel == 3'd2) ? 1 : (path_sel == 3'd4) ? 2 : -1;
    ok = div_en && front_en && depth >= 0;
    d2 = (depth >= 1) ? div_of(mid_code) : 0;
    d3 = (depth >= 2) ? div_of(back_code) : 0;
    if (depth >= 1) ok = ok && mid_en && d2 != 0;
    if (depth >= 2) ok = ok && back_en && d3 != 0;
    key = int'(path_sel) * 100000 + int'(front_odd) * 10000 + d2 * 100 + d3;
    if (!ok || key != pkey) k = 0;
    else if (run_m) k++;
    run_m = ok;
    pkey  = key;
    per   = (front_odd ? 3 : 2) * (d2 != 0 ? d2 : 1) * (d3 != 0 ? d3 : 1);
  endtask

  task automatic check(int h);
    logic exp;
    if (out_sel == 2'd1) exp = (h == 0);
    else if (out_sel != 2'd0) exp = 1'b0;
    else if (!run_m) exp = 1'b0;
    else exp = ((2 * (k % per) + h) < per);
    n_vec++;
    if (clk_out !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t half=%0d k=%0d period=%0d got %0b expected %0b",
               req, $time, h, k, per, clk_out, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      model_step();
      check(0);
      @(negedge clk); #1;
      check(1);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; div_en = 0; front_en = 1; front_odd = 0; mid_en = 1; back_en = 1;
    mid_code = 4'd1; back_code = 4'd1; path_sel = 3'd1; out_sel = 2'd0;
    req = "R9"; cyc(3);
    rst_n = 1; cyc(5);

    req = "R1"; div_en = 1; cyc(12);
    front_odd = 1; cyc(15);

    req = "R2"; path_sel = 3'd2;
    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 4; c++) begin
        front_odd = o[0]; mid_code = 4'd1 << c; cyc(40);
      end
    path_sel = 3'd4;
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 4; b++) begin
        front_odd = m[0] ^ b[0];
        mid_code = 4'd1 << m; back_code = 4'd1 << b;
        cyc(2 * (front_odd ? 3 : 2) * div_of(mid_code) * div_of(back_code) + 3);
      end

    req = "R3"; path_sel = 3'd0; cyc(8);
    path_sel = 3'd3; cyc(8);
    path_sel = 3'd2; mid_code = 4'd4; cyc(10);

    req = "R5"; cyc(5);
    back_code = 4'd0; back_en = 0; cyc(9);
    back_code = 4'd8; cyc(7);
    mid_en = 0; cyc(8);
    mid_en = 1; cyc(10);
    front_en = 0; cyc(6);
    front_en = 1; path_sel = 3'd1; cyc(4);
    mid_en = 0; mid_code = 4'd0; cyc(10);
    mid_en = 1; mid_code = 4'd2; back_en = 1;

    req = "R4"; path_sel = 3'd2; mid_code = 4'd3; cyc(8);
    mid_code = 4'd0; cyc(8);
    path_sel = 3'd4; mid_code = 4'd2; back_code = 4'd5; cyc(8);

    req = "R6"; back_code = 4'd2; cyc(50);
    div_en = 0; cyc(6);
    div_en = 1; cyc(50);

    req = "R7"; path_sel = 3'd2; mid_code = 4'd8; front_odd = 0; cyc(7);
    mid_code = 4'd4; cyc(20);
    cyc(5); front_odd = 1; cyc(20);
    path_sel = 3'd4; back_code = 4'd1; cyc(9);
    mid_code = 4'd1; cyc(15);

    req = "R8"; out_sel = 2'd1; cyc(6);
    out_sel = 2'd2; cyc(6);
    out_sel = 2'd3; cyc(6);
    out_sel = 2'd0; cyc(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule